// File: doc/BRIEF.md
# Break Fault Filter and Main Output Enable Control

This block guards the power stage of a PWM timer. A raw fault pin first passes through a polarity and enable stage. It then goes through a digital glitch filter. A 4-bit code picks two things for that filter: how often it samples, which is every kernel clock or every D-th pulse of a divided tick enable, and how many matching samples in a row it needs before the filtered level may change. Code zero skips the filter, so the fault acts in the same cycle it appears.

A filtered fault clears the main output enable at once. While the fault stays active, no request can set the enable again. After the fault has gone, software sets the enable again. When automatic enable is selected, an update event can also set it. The fault stays latched in a break-active flag until the enable is back or the fault is disarmed. In bidirectional mode, the block pulls the fault pin low through an open-drain drive to signal the fault to other devices. Software can release that drive with a disarm request. Hardware clears the disarm request once the fault has gone.

While the enable is low, a 2-bit off-state code tells the output stage what to do. Either the pins are released to high impedance, or they are driven to their inactive level for a programmable dead time and then to their idle level.

Top module: `fault_gate`

## Requirements
- R1: After reset, moe_o, brk_act_o, pin_drive_o and disarm_o are all 0.
- R2: The fault is active when brk_en_i=1 and brk_pin_i equals brk_pol_i (pol 1 = active high, pol 0 = active low). With brk_en_i=0 the pin has no effect on any output.
- R3: With flt_code_i=0 the filter is bypassed, and an active fault forces moe_o to 0 in the same cycle, with no clock edge needed.
- R4: Codes 1, 2 and 3 sample on every clock and need 2, 4 and 8 consecutive samples of the new level. The filtered level changes on the N-th such edge. A single mismatching sample restarts the count. This applies both when the fault asserts and when it clears.
- R5: Codes 4 to 15 sample on every D-th cycle where tick_i=1. The pairs (D, N) are: codes 4/5 (2, 6/8), codes 6/7 (4, 6/8), codes 8/9 (8, 6/8), codes 10/11/12 (16, 5/6/8), codes 13/14/15 (32, 5/6/8). With tick_i held at 1, a new level shows after N×D edges. With tick_i held at 0, the filtered level never changes.
- R6: While the filtered fault is active, moe_o is 0, and an oe_set_i pulse does not raise it.
- R7: With no fault active, an oe_set_i pulse raises moe_o after one edge, and an oe_clr_i pulse lowers it after one edge.
- R8: When auto_oe_i=1, an upd_evt_i at an edge with no filtered fault active sets moe_o. When auto_oe_i=0, upd_evt_i has no effect on moe_o.
- R9: brk_act_o goes to 1 with the filtered fault. It stays 1 after the fault clears, and drops one edge after moe_o is set again or in the edge where a pending disarm sees the fault gone.
- R10: pin_drive_o (1 = pull the fault pin low) equals bidir_i AND brk_act_o AND NOT disarm_o. It is never 1 when bidir_i=0.
- R11: A disarm_set_i pulse sets disarm_o after one edge, even while the fault is still active. Hardware clears disarm_o at the first edge with no filtered fault active.
- R12: out_mode_o is 0 (run) while moe_o=1. While moe_o=0, it is 1 (high impedance) if idle_sel_i=0. If idle_sel_i=1, it is 2 (inactive level) for dead_time_i cycles after moe_o falls, and 3 (idle level) after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Divided tick enable that sets the slow sampling rates |
| brk_pin_i | input | 1 | Raw fault pin level |
| upd_evt_i | input | 1 | Timer update event, one cycle per event |
| brk_en_i | input | 1 | Enables the fault function |
| brk_pol_i | input | 1 | Active level of the fault pin |
| flt_code_i | input | 4 | Filter rate and sample-count code |
| auto_oe_i | input | 1 | Lets an update event set the enable again |
| oe_set_i | input | 1 | Software request to set the enable |
| oe_clr_i | input | 1 | Software request to clear the enable |
| disarm_set_i | input | 1 | Software disarm request |
| bidir_i | input | 1 | Selects open-drain signalling of faults on the pin |
| idle_sel_i | input | 1 | Off-state choice while the enable is low |
| dead_time_i | input | DT_W | Cycles spent at the inactive level before the idle level |
| moe_o | output | 1 | Main output enable |
| brk_act_o | output | 1 | Break-active flag |
| pin_drive_o | output | 1 | 1 = open-drain pulls the fault pin low |
| disarm_o | output | 1 | Disarm state |
| out_mode_o | output | 2 | Off-state code for the output stage |

## Verification
The filter is tested with steady assertions at kernel-rate and tick-rate codes, which checks the exact N×D latency. A burst that drops for one sample before the full count shows that the count restarts rather than continuing. A long stretch with tick_i held low shows that the slow sampling rates depend on the tick and not on the clock. Release sequences under automatic enable show that the filter is symmetric and that an update event cannot set the enable while the fault is active. Disarm during an active fault, followed by the fault clearing, separates release of the drive from clearing of the latch. Dead-time runs with nonzero and zero length separate the inactive and idle phases.

// File: rtl/fault_gate_pkg.sv
`timescale 1ns/1ps
package fault_gate_pkg;
  localparam int CODE_W   = 4;
  localparam int MAX_DIV  = 32;
  localparam int MAX_NEED = 8;
  localparam int PRE_W    = $clog2(MAX_DIV);
  localparam int CNT_W    = $clog2(MAX_NEED);

  typedef enum logic [1:0] {
    OM_RUN   = 2'd0,
    OM_HIZ   = 2'd1,
    OM_INACT = 2'd2,
    OM_IDLE  = 2'd3
  } out_mode_e;

  typedef struct packed {
    logic       bypass;
    logic       kernel;
    logic [5:0] div;
    logic [3:0] need;
  } flt_cfg_t;

  // Map the filter code to sampling divider and consecutive-sample count.
  function automatic flt_cfg_t flt_decode(input logic [CODE_W-1:0] code);
    flt_cfg_t c;
    logic [3:0] sub;
    c = '{bypass: 1'b0, kernel: 1'b0, div: 6'd1, need: 4'd1};
    sub = 4'd0;
    if (code == 4'd0) begin
      c.bypass = 1'b1;
    end else if (code <= 4'd3) begin
      c.kernel = 1'b1;
      c.need   = 4'd1 << code;
    end else if (code <= 4'd9) begin
      c.div  = 6'd2 << ((code - 4'd4) >> 1);
      c.need = code[0] ? 4'd8 : 4'd6;
    end else begin
      c.div = (code <= 4'd12) ? 6'd16 : 6'd32;
      sub   = (code <= 4'd12) ? (code - 4'd10) : (code - 4'd13);
      case (sub)
        4'd0:    c.need = 4'd5;
        4'd1:    c.need = 4'd6;
        default: c.need = 4'd8;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/fg_filter.sv
`timescale 1ns/1ps
module fg_filter
  import fault_gate_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     raw_i,
  input  flt_cfg_t cfg_i,
  output logic     lvl_o,
  output logic     stb_o
);
  logic             lvl_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pending;
  logic             pre_wrap;
  logic             done;

  assign pending  = raw_i ^ lvl_q;
  assign pre_wrap = (pre_q == PRE_W'(cfg_i.div - 6'd1));
  assign stb_o    = pending & ~cfg_i.bypass & (cfg_i.kernel | (tick_i & pre_wrap));
  assign done     = (cnt_q == CNT_W'(cfg_i.need - 4'd1));
  assign lvl_o    = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      pre_q <= '0;
      cnt_q <= '0;
    end else if (cfg_i.bypass) begin
      lvl_q <= raw_i;
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!pending) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (tick_i && !cfg_i.kernel) begin
        pre_q <= pre_wrap ? '0 : pre_q + PRE_W'(1);
      end
      if (stb_o) begin
        if (done) begin
          lvl_q <= raw_i;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fg_oe_ctrl.sv
`timescale 1ns/1ps
module fg_oe_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic brk_now_i,
  input  logic oe_set_i,
  input  logic oe_clr_i,
  input  logic auto_oe_i,
  input  logic upd_evt_i,
  input  logic disarm_set_i,
  input  logic bidir_i,
  output logic moe_q_o,
  output logic moe_o,
  output logic act_o,
  output logic disarm_o,
  output logic drive_o
);
  logic moe_q, lat_q, dis_q;
  logic rearm_req;

  assign rearm_req = oe_set_i | (auto_oe_i & upd_evt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      moe_q <= 1'b0;
      lat_q <= 1'b0;
      dis_q <= 1'b0;
    end else begin
      if (brk_now_i)      moe_q <= 1'b0;
      else if (oe_clr_i)  moe_q <= 1'b0;
      else if (rearm_req) moe_q <= 1'b1;

      if (brk_now_i)              lat_q <= 1'b1;
      else if (dis_q || moe_q)    lat_q <= 1'b0;

      if (disarm_set_i)    dis_q <= 1'b1;
      else if (!brk_now_i) dis_q <= 1'b0;
    end
  end

  assign moe_q_o  = moe_q;
  assign moe_o    = moe_q & ~brk_now_i;
  assign act_o    = lat_q | brk_now_i;
  assign disarm_o = dis_q;
  assign drive_o  = bidir_i & ~dis_q & (lat_q | brk_now_i);
endmodule

// File: rtl/fg_offstate.sv
`timescale 1ns/1ps
module fg_offstate
  import fault_gate_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            moe_i,
  input  logic            idle_sel_i,
  input  logic [DT_W-1:0] dead_time_i,
  output out_mode_e       mode_o
);
  logic [DT_W-1:0] dt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dt_q <= '0;
    else if (moe_i)             dt_q <= '0;
    else if (dt_q < dead_time_i) dt_q <= dt_q + DT_W'(1);
  end

  always_comb begin
    if (moe_i)                   mode_o = OM_RUN;
    else if (!idle_sel_i)        mode_o = OM_HIZ;
    else if (dt_q >= dead_time_i) mode_o = OM_IDLE;
    else                         mode_o = OM_INACT;
  end
endmodule

// File: rtl/fault_gate.sv
`timescale 1ns/1ps
module fault_gate
  import fault_gate_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              brk_pin_i,
  input  logic              upd_evt_i,
  input  logic              brk_en_i,
  input  logic              brk_pol_i,
  input  logic [CODE_W-1:0] flt_code_i,
  input  logic              auto_oe_i,
  input  logic              oe_set_i,
  input  logic              oe_clr_i,
  input  logic              disarm_set_i,
  input  logic              bidir_i,
  input  logic              idle_sel_i,
  input  logic [DT_W-1:0]   dead_time_i,
  output logic              moe_o,
  output logic              brk_act_o,
  output logic              pin_drive_o,
  output logic              disarm_o,
  output logic [1:0]        out_mode_o
);
  flt_cfg_t  cfg;
  logic      brk_raw;
  logic      flt_lvl;
  logic      smp_stb;
  logic      brk_now;
  logic      moe_q;
  out_mode_e mode;

  assign cfg     = flt_decode(flt_code_i);
  assign brk_raw = brk_en_i & ~(brk_pin_i ^ brk_pol_i);
  assign brk_now = cfg.bypass ? brk_raw : flt_lvl;

  fg_filter u_flt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .raw_i  (brk_raw),
    .cfg_i  (cfg),
    .lvl_o  (flt_lvl),
    .stb_o  (smp_stb)
  );

  fg_oe_ctrl u_oe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .brk_now_i    (brk_now),
    .oe_set_i     (oe_set_i),
    .oe_clr_i     (oe_clr_i),
    .auto_oe_i    (auto_oe_i),
    .upd_evt_i    (upd_evt_i),
    .disarm_set_i (disarm_set_i),
    .bidir_i      (bidir_i),
    .moe_q_o      (moe_q),
    .moe_o        (moe_o),
    .act_o        (brk_act_o),
    .disarm_o     (disarm_o),
    .drive_o      (pin_drive_o)
  );

  fg_offstate #(.DT_W(DT_W)) u_off (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .moe_i       (moe_o),
    .idle_sel_i  (idle_sel_i),
    .dead_time_i (dead_time_i),
    .mode_o      (mode)
  );

  assign out_mode_o = mode;
endmodule

// File: rtl/fault_gate_chk.sv
`timescale 1ns/1ps
module fault_gate_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] flt_code_i,
  input logic       oe_set_i,
  input logic       auto_oe_i,
  input logic       upd_evt_i,
  input logic       disarm_set_i,
  input logic       bidir_i,
  input logic       brk_now,
  input logic       smp_stb,
  input logic       flt_lvl,
  input logic       moe_q,
  input logic       moe_o,
  input logic       brk_act_o,
  input logic       pin_drive_o,
  input logic       disarm_o,
  input logic [1:0] out_mode_o
);
  p_hold_no_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_code_i != 4'd0 && !smp_stb) |=> $stable(flt_lvl));

  p_fault_blocks_moe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_now |-> !moe_o);

  p_rise_needs_request_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(moe_q) |-> ($past(oe_set_i) || $past(auto_oe_i && upd_evt_i)));

  p_no_auto_no_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!moe_q && !oe_set_i && !(auto_oe_i && upd_evt_i)) |=> !moe_q);

  p_drive_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_drive_o |-> (bidir_i && brk_act_o && !disarm_o));

  p_disarm_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disarm_o && !brk_now && !disarm_set_i) |=> !disarm_o);

  p_run_when_enabled_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    moe_o |-> (out_mode_o == 2'd0));
endmodule

bind fault_gate fault_gate_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flt_code_i   (flt_code_i),
  .oe_set_i     (oe_set_i),
  .auto_oe_i    (auto_oe_i),
  .upd_evt_i    (upd_evt_i),
  .disarm_set_i (disarm_set_i),
  .bidir_i      (bidir_i),
  .brk_now      (brk_now),
  .smp_stb      (smp_stb),
  .flt_lvl      (flt_lvl),
  .moe_q        (moe_q),
  .moe_o        (moe_o),
  .brk_act_o    (brk_act_o),
  .pin_drive_o  (pin_drive_o),
  .disarm_o     (disarm_o),
  .out_mode_o   (out_mode_o)
);

// File: tb/sim_fault_gate.sv
`timescale 1ns/1ps
module sim_fault_gate;
  localparam int MOE  = 0;
  localparam int ACT  = 1;
  localparam int DRV  = 2;
  localparam int DIS  = 3;
  localparam int MODE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, pin = 1'b0, upd = 1'b0, en = 1'b1, pol = 1'b1;
  logic [3:0] code = 4'd0;
  logic       auto_oe = 1'b0, oe_set = 1'b0, oe_clr = 1'b0, dis_set = 1'b0;
  logic       bidir = 1'b0, idle = 1'b0;
  logic [7:0] dead = 8'd4;
  logic       moe, act, drv, dis;
  logic [1:0] mode;

  always #2 clk = ~clk;

  fault_gate #(.DT_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .brk_pin_i(pin), .upd_evt_i(upd),
    .brk_en_i(en), .brk_pol_i(pol), .flt_code_i(code), .auto_oe_i(auto_oe),
    .oe_set_i(oe_set), .oe_clr_i(oe_clr), .disarm_set_i(dis_set), .bidir_i(bidir),
    .idle_sel_i(idle), .dead_time_i(dead), .moe_o(moe), .brk_act_o(act),
    .pin_drive_o(drv), .disarm_o(dis), .out_mode_o(mode)
  );

  typedef struct {
    int    cyc;
    int    sig;
    int    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc_n  = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  function automatic int probe(input int sig);
    case (sig)
      MOE:     return int'(moe);
      ACT:     return int'(act);
      DRV:     return int'(drv);
      DIS:     return int'(dis);
      default: return int'(mode);
    endcase
  endfunction

  task automatic compare(input int sig, input int val, input string tag);
    checks++;
    if (probe(sig) != val) begin
      errors++;
      $display("FAIL %s sig=%0d cycle=%0d actual=%0d expected=%0d",
               tag, sig, cyc_n, probe(sig), val);
    end
  endtask

  task automatic expect_in(input int d, input int sig, input int val, input string tag);
    q.push_back(exp_t'{cyc_n + d, sig, val, tag});
  endtask

  // Monitor: samples 1 ns after each rising edge and retires due items.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc_n++;
      for (int i = 0; i < q.size(); ) begin
        if (q[i].cyc == cyc_n) begin
          compare(q[i].sig, q[i].val, q[i].tag);
          q.delete(i);
        end else begin
          i++;
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm();
    oe_set = 1'b1;
    step(1);
    oe_set = 1'b0;
    step(2);
  endtask

  task automatic release_auto(input int lat);
    pin = 1'b0; auto_oe = 1'b1; upd = 1'b1;
    expect_in(lat, MOE, 0, "R8 release");
    expect_in(lat + 1, MOE, 1, "R8 release");
    step(lat + 2);
    auto_oe = 1'b0; upd = 1'b0;
    step(2);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    #1;
    compare(MOE, 0, "R1"); compare(ACT, 0, "R1"); compare(DRV, 0, "R1");
    compare(DIS, 0, "R1"); compare(MODE, 1, "R12 reset hiz");
    step(1);

    // R7: software set and clear
    oe_set = 1'b1; expect_in(1, MOE, 1, "R7 set"); expect_in(1, MODE, 0, "R12 run");
    step(1); oe_set = 1'b0;
    step(1);
    oe_clr = 1'b1; expect_in(1, MOE, 0, "R7 clr"); expect_in(1, MODE, 1, "R12 hiz");
    step(1); oe_clr = 1'b0;
    arm();

    // R3 bypass acts without an edge; R9 latch
    pin = 1'b1; #1;
    compare(MOE, 0, "R3"); compare(ACT, 1, "R9 set");
    step(1);
    pin = 1'b0;
    expect_in(1, ACT, 1, "R9 latched"); expect_in(1, MOE, 0, "R6 stays low");
    step(2);
    oe_set = 1'b1;
    expect_in(1, MOE, 1, "R7 reset"); expect_in(1, ACT, 1, "R9 hold");
    expect_in(2, ACT, 0, "R9 clear");
    step(1); oe_set = 1'b0; step(2);

    // R6 set blocked while active; R8 no auto means update ignored
    pin = 1'b1; step(1);
    oe_set = 1'b1; expect_in(1, MOE, 0, "R6 set blocked");
    step(1);
    oe_set = 1'b0; pin = 1'b0; upd = 1'b1;
    expect_in(3, MOE, 0, "R8 no auto");
    step(3); upd = 1'b0;
    arm();

    // R2 polarity and enable
    pol = 1'b0; #1;
    compare(MOE, 0, "R2 active low");
    step(1); pin = 1'b1;
    arm();
    en = 1'b0; pin = 1'b0;
    expect_in(3, MOE, 1, "R2 disabled"); expect_in(3, ACT, 0, "R2 disabled");
    step(4);
    pin = 1'b0; pol = 1'b1; en = 1'b1;
    step(1);

    // R4 kernel-rate filter
    code = 4'd1; step(1);
    pin = 1'b1;
    expect_in(1, MOE, 1, "R4 n2 early"); expect_in(2, MOE, 0, "R4 n2");
    step(3);
    release_auto(2);
    code = 4'd3; step(1);
    pin = 1'b1; step(5);
    pin = 1'b0; step(1);
    pin = 1'b1;
    expect_in(7, MOE, 1, "R4 restart"); expect_in(8, MOE, 0, "R4 n8");
    step(9);
    release_auto(8);

    // R5 tick-rate filter
    tick = 1'b1; code = 4'd4; step(1);
    pin = 1'b1;
    expect_in(11, MOE, 1, "R5 code4 early"); expect_in(12, MOE, 0, "R5 code4");
    step(13);
    release_auto(12);
    code = 4'd10; step(1);
    pin = 1'b1;
    expect_in(79, MOE, 1, "R5 code10 early"); expect_in(80, MOE, 0, "R5 code10");
    step(81);
    tick = 1'b0; pin = 1'b0; auto_oe = 1'b1; upd = 1'b1;
    expect_in(200, MOE, 0, "R5 no tick");
    step(200);
    tick = 1'b1;
    expect_in(80, MOE, 0, "R5 resume"); expect_in(81, MOE, 1, "R5 resume");
    step(82);
    auto_oe = 1'b0; upd = 1'b0; step(2);
    code = 4'd13; step(1);
    pin = 1'b1;
    expect_in(159, MOE, 1, "R5 code13 early"); expect_in(160, MOE, 0, "R5 code13");
    step(161);
    release_auto(160);
    code = 4'd0; step(2);

    // R10 / R11 bidirectional drive and disarm
    bidir = 1'b1;
    pin = 1'b1; #1;
    compare(DRV, 1, "R10 drive");
    step(1);
    dis_set = 1'b1;
    expect_in(1, DRV, 0, "R11 release"); expect_in(1, DIS, 1, "R11 set");
    expect_in(1, ACT, 1, "R11 still latched");
    step(1); dis_set = 1'b0;
    expect_in(2, DIS, 1, "R11 held");
    step(3);
    pin = 1'b0;
    expect_in(1, DIS, 0, "R11 hw clear"); expect_in(1, ACT, 0, "R9 disarm clear");
    expect_in(1, DRV, 0, "R10 released");
    step(2);
    arm();
    bidir = 1'b0; pin = 1'b1; #1;
    compare(DRV, 0, "R10 no bidir");
    step(1); pin = 1'b0; step(1);
    arm();

    // R12 off-state sequencing
    idle = 1'b1; dead = 8'd4;
    pin = 1'b1; #1;
    compare(MODE, 2, "R12 inactive");
    expect_in(3, MODE, 2, "R12 inactive hold"); expect_in(4, MODE, 3, "R12 idle");
    step(5);
    pin = 1'b0; step(1);
    arm();
    dead = 8'd0; pin = 1'b1; #1;
    compare(MODE, 3, "R12 zero dead");
    step(1);
    idle = 1'b0; #1;
    compare(MODE, 1, "R12 hiz");
    step(3);

    while (q.size() != 0) step(1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule